// File: doc/BRIEF.md
# SDRAM Byte-Mask and Clock-Suspend Beat Aligner

This block sits in the datapath of an SDRAM controller, next to one group of data byte lanes. The command scheduler tells it when a read or write burst starts, which direction it has and how long it is. The block then follows the burst beat by beat. A host supplies a per-byte mask for every beat. The block drives the byte-mask pins at the cycle the memory needs them, drives the clock-enable line for clock suspension, enables the write-data drivers, and marks which returned read beats carry valid bytes.

The memory handles masking differently in the two directions. A write beat is masked in the same clock as the mask. A read beat is blanked two memory clocks after the mask is seen. The block therefore leads the mask of each read beat by CAS latency minus two clocks and lines up the read strobes to match. Clock suspension freezes the memory for whole cycles. The block counts beats and return latency in memory clocks only, so a suspension stretches a burst and its returned data without losing or adding beats. A truncation input forces all bytes masked for the rest of the current burst.

Top module: `sdram_dqm_aligner`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, cke is 1 and dqm, wr_oe, rd_valid and rd_be are all 0.
- R2: cke is the inverse of suspend_req as sampled at the previous clock edge.
- R3: A cycle is frozen when cke was 0 in the previous cycle. In a frozen cycle, dqm is all ones, wr_oe is 0 and rd_valid is 0, and no beat is counted.
- R4: A start_valid pulse is taken only when no burst is active and no read beat is still in flight. A pulse at any other time has no effect on any output.
- R5: start_len encodes the beat count as 0=1, 1=2, 2=4, 3=8. The burst occupies exactly that many non-frozen cycles, beginning with the cycle after the start is taken.
- R6: In each write beat cycle, wr_oe is 1 and dqm equals that cycle's host_mask (bit set = byte masked), with no added latency.
- R7: For a read beat issued in non-frozen cycle s, dqm carries that beat's mask in the non-frozen cycle that comes CL-2 non-frozen cycles after s. Outside such cycles and write beats, dqm is 0 in non-frozen cycles.
- R8: The data of that read beat returns CL non-frozen cycles after s. In that cycle, rd_be is the inverse of the beat's mask (bit set = byte valid) and rd_valid is 1 exactly when rd_be is nonzero.
- R9: trunc_req in a beat cycle forces all bytes masked for that beat and for every later beat of the same burst. The next burst starts unmasked.
- R10: Frozen cycles inside a burst or its read return delay the remaining beats and returns by exactly the number of frozen cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_valid | input | 1 | Burst start pulse from the scheduler |
| start_write | input | 1 | 1 = write burst, 0 = read burst |
| start_len | input | 2 | Burst length code (0..3 = 1,2,4,8 beats) |
| host_mask | input | NB | Per-byte mask for the current beat, 1 = masked |
| trunc_req | input | 1 | Mask the rest of the current burst |
| suspend_req | input | 1 | Request a clock-suspend cycle |
| cke | output | 1 | Clock enable to the memory |
| dqm | output | NB | Byte-mask pins to the memory |
| wr_oe | output | 1 | Write-data driver enable |
| rd_valid | output | 1 | A returned read beat has at least one valid byte |
| rd_be | output | NB | Byte enables of the returned read beat |

## Verification
Several events can fall in the same cycle. A suspension can begin while a read burst is still issuing beats and while earlier beats are returning. A truncation can also coincide with the cycle just before a freeze. The bench places suspend_req in the middle of read bursts with CL of three, so that a frozen cycle lands between the mask lead and the data return of one beat. It also raises trunc_req one cycle before a suspension. A reference model that counts memory clocks with integers judges the outcome every cycle. A checker also confirms that no returned byte is enabled when its mask was high two memory clocks earlier.

// File: rtl/sdram_dqm_pkg.sv
package sdram_dqm_pkg;

  // Beat count for a two-bit length code: 1, 2, 4 or 8.
  function automatic int unsigned beats_of(input logic [1:0] code);
    return 32'd1 << code;
  endfunction

  // Non-frozen cycles between a read beat slot and its mask on the pins.
  function automatic int unsigned mask_lead(input int unsigned cas_lat);
    return cas_lat - 2;
  endfunction

endpackage

// File: rtl/sdram_cke_ctrl.sv
module sdram_cke_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic suspend_req,
  output logic cke_o,
  output logic frozen_o
);
  // The memory sees cke at an edge; its internal clock stops one cycle later.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cke_o    <= 1'b1;
      frozen_o <= 1'b0;
    end else begin
      cke_o    <= ~suspend_req;
      frozen_o <= ~cke_o;
    end
  end
endmodule

// File: rtl/sdram_burst_track.sv
module sdram_burst_track #(
  parameter int unsigned MAX_BL = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       start_ok,
  input  logic       start_write,
  input  logic [1:0] start_len,
  input  logic       trunc_req,
  output logic       active_o,
  output logic       is_write_o,
  output logic       slot_o,
  output logic       force_o
);
  import sdram_dqm_pkg::*;
  localparam int unsigned CNT_W = $clog2(MAX_BL + 1);

  logic [CNT_W-1:0] left_q;
  logic             forced_q;

  assign slot_o  = active_o & tick;
  assign force_o = forced_q | trunc_req;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_o   <= 1'b0;
      is_write_o <= 1'b0;
      left_q     <= '0;
      forced_q   <= 1'b0;
    end else if (start_ok) begin
      active_o   <= 1'b1;
      is_write_o <= start_write;
      left_q     <= CNT_W'(beats_of(start_len));
      forced_q   <= 1'b0;
    end else if (slot_o) begin
      forced_q <= forced_q | trunc_req;
      left_q   <= left_q - 1'b1;
      if (left_q == CNT_W'(1)) active_o <= 1'b0;
    end
  end
endmodule

// File: rtl/sdram_rd_pipe.sv
module sdram_rd_pipe #(
  parameter int unsigned NB = 2,
  parameter int unsigned CL = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          push,
  input  logic [NB-1:0] push_mask,
  output logic          lead_v,
  output logic [NB-1:0] lead_mask,
  output logic          ret_v,
  output logic [NB-1:0] ret_mask,
  output logic          any_v
);
  import sdram_dqm_pkg::*;
  localparam int unsigned LEAD = mask_lead(CL);

  logic [CL-1:0] st_v;
  logic [NB-1:0] st_m [CL];

  // Stage j holds a beat issued j+1 memory clocks ago; it advances only on ticks.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_v <= '0;
      for (int i = 0; i < CL; i++) st_m[i] <= '0;
    end else if (tick) begin
      st_v[0] <= push;
      st_m[0] <= push_mask;
      for (int i = 1; i < CL; i++) begin
        st_v[i] <= st_v[i-1];
        st_m[i] <= st_m[i-1];
      end
    end
  end

  generate
    if (LEAD == 0) begin : g_lead_now
      assign lead_v    = push;
      assign lead_mask = push_mask;
    end else begin : g_lead_staged
      assign lead_v    = st_v[LEAD-1];
      assign lead_mask = st_m[LEAD-1];
    end
  endgenerate

  assign ret_v    = st_v[CL-1];
  assign ret_mask = st_m[CL-1];
  assign any_v    = |st_v;
endmodule

// File: rtl/sdram_dqm_aligner.sv
module sdram_dqm_aligner #(
  parameter int unsigned NB     = 2,
  parameter int unsigned CL     = 3,
  parameter int unsigned MAX_BL = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_valid,
  input  logic          start_write,
  input  logic [1:0]    start_len,
  input  logic [NB-1:0] host_mask,
  input  logic          trunc_req,
  input  logic          suspend_req,
  output logic          cke,
  output logic [NB-1:0] dqm,
  output logic          wr_oe,
  output logic          rd_valid,
  output logic [NB-1:0] rd_be
);
  // Named internal events, visible to the bound checker.
  logic          frozen;
  logic          tick;
  logic          busy;
  logic          start_ok;
  logic          active;
  logic          is_write;
  logic          slot;
  logic          force_now;
  logic [NB-1:0] beat_mask;
  logic          rd_push;
  logic          lead_v;
  logic [NB-1:0] lead_mask;
  logic          ret_v;
  logic [NB-1:0] ret_mask;
  logic          rd_any;

  sdram_cke_ctrl u_cke (
    .clk(clk), .rst_n(rst_n), .suspend_req(suspend_req),
    .cke_o(cke), .frozen_o(frozen)
  );

  assign tick     = ~frozen;
  assign busy     = active | rd_any;
  assign start_ok = start_valid & ~busy;

  sdram_burst_track #(.MAX_BL(MAX_BL)) u_track (
    .clk(clk), .rst_n(rst_n), .tick(tick), .start_ok(start_ok),
    .start_write(start_write), .start_len(start_len), .trunc_req(trunc_req),
    .active_o(active), .is_write_o(is_write), .slot_o(slot), .force_o(force_now)
  );

  assign beat_mask = host_mask | {NB{force_now}};
  assign rd_push   = slot & ~is_write;

  sdram_rd_pipe #(.NB(NB), .CL(CL)) u_rd (
    .clk(clk), .rst_n(rst_n), .tick(tick), .push(rd_push), .push_mask(beat_mask),
    .lead_v(lead_v), .lead_mask(lead_mask), .ret_v(ret_v), .ret_mask(ret_mask),
    .any_v(rd_any)
  );

  always_comb begin
    if (frozen)              dqm = '1;
    else if (slot & is_write) dqm = beat_mask;
    else if (lead_v)         dqm = lead_mask;
    else                     dqm = '0;
  end

  assign wr_oe    = slot & is_write;
  assign rd_be    = (tick & ret_v) ? ~ret_mask : '0;
  assign rd_valid = |rd_be;
endmodule

// File: rtl/sdram_dqm_aligner_chk.sv
module sdram_dqm_aligner_chk #(
  parameter int unsigned NB = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          suspend_req,
  input logic          cke,
  input logic [NB-1:0] dqm,
  input logic          wr_oe,
  input logic          rd_valid,
  input logic [NB-1:0] rd_be,
  input logic          frozen
);
  logic          prev_cke;
  logic [1:0]    ticks_seen;
  logic [NB-1:0] dqm_t1;
  logic [NB-1:0] dqm_t2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_cke   <= 1'b1;
      ticks_seen <= '0;
      dqm_t1     <= '0;
      dqm_t2     <= '0;
    end else begin
      prev_cke <= cke;
      if (prev_cke) begin
        dqm_t1 <= dqm;
        dqm_t2 <= dqm_t1;
        if (ticks_seen != 2'd2) ticks_seen <= ticks_seen + 2'd1;
      end
    end
  end

  assert_cke_enter_R2: assert property (@(posedge clk) disable iff (!rst_n)
    suspend_req |=> !cke);
  assert_cke_exit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !suspend_req |=> cke);
  assert_frozen_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !prev_cke |-> (!wr_oe && !rd_valid && (&dqm)));
  assert_frozen_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    frozen == !prev_cke);
  assert_rd_mask_two_clk_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (prev_cke && ticks_seen == 2'd2 && rd_valid) |-> ((rd_be & dqm_t2) == '0));
  assert_no_dir_overlap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_oe && rd_valid));
endmodule

bind sdram_dqm_aligner sdram_dqm_aligner_chk #(.NB(NB)) u_chk (
  .clk(clk), .rst_n(rst_n), .suspend_req(suspend_req), .cke(cke), .dqm(dqm),
  .wr_oe(wr_oe), .rd_valid(rd_valid), .rd_be(rd_be), .frozen(frozen)
);

// File: tb/tb_sdram_dqm_aligner.sv
module tb_sdram_dqm_aligner;
  localparam int NB = 2;
  localparam int CL = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_valid = 1'b0, start_write = 1'b0, trunc_req = 1'b0, suspend_req = 1'b0;
  logic [1:0] start_len = '0;
  logic [NB-1:0] host_mask = '0;
  logic cke, wr_oe, rd_valid;
  logic [NB-1:0] dqm, rd_be;

  always #2 clk = ~clk;

  sdram_dqm_aligner #(.NB(NB), .CL(CL), .MAX_BL(8)) dut (
    .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_write(start_write),
    .start_len(start_len), .host_mask(host_mask), .trunc_req(trunc_req),
    .suspend_req(suspend_req), .cke(cke), .dqm(dqm), .wr_oe(wr_oe),
    .rd_valid(rd_valid), .rd_be(rd_be)
  );

  int checks = 0;
  int errors = 0;
  string scen = "reset";

  typedef struct { int t; logic [NB-1:0] m; } ev_t;
  ev_t lead_q[$];
  ev_t ret_q[$];
  bit m_cke = 1, m_frz = 0, m_act = 0, m_wr = 0, m_force = 0;
  int m_left = 0;
  int T = 0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input string req, input int got, input int exp, input string what);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s [%s] %s got %0h expected %0h", req, scen, what, got, exp);
    end
  endtask

  task automatic step(input bit sv, input bit sw, input logic [1:0] sl,
                      input logic [NB-1:0] hm, input bit tr, input bit sp);
    bit tk, slot, busy;
    logic [NB-1:0] bm, e_dqm, e_be;
    bit e_oe;
    string dreq;
    @(negedge clk);
    start_valid = sv; start_write = sw; start_len = sl;
    host_mask = hm; trunc_req = tr; suspend_req = sp;
    #1;
    tk = !m_frz;
    busy = m_act || (ret_q.size() > 0);
    slot = m_act && tk;
    bm = hm | ((m_force || tr) ? {NB{1'b1}} : {NB{1'b0}});
    e_dqm = '0; e_be = '0; e_oe = 0; dreq = "R7";
    if (!tk) begin
      e_dqm = '1; dreq = "R3";
    end else begin
      if (slot && m_wr) begin
        e_oe = 1; e_dqm = bm; dreq = (m_force || tr) ? "R9" : "R6";
      end else if (slot) begin
        lead_q.push_back('{T + CL - 2, bm});
        ret_q.push_back('{T + CL, bm});
        if (m_force || tr) dreq = "R9";
      end
      foreach (lead_q[i]) if (lead_q[i].t == T) e_dqm = lead_q[i].m;
      foreach (ret_q[i])  if (ret_q[i].t == T)  e_be = ~ret_q[i].m;
    end
    chk("R2", int'(cke), int'(m_cke), "cke");
    chk(dreq, int'(dqm), int'(e_dqm), "dqm");
    chk(tk ? "R5" : "R3", int'(wr_oe), int'(e_oe), "wr_oe");
    chk("R8", int'(rd_be), int'(e_be), "rd_be");
    chk("R8", int'(rd_valid), int'(e_be != 0), "rd_valid");
    @(posedge clk);
    if (tk) begin
      if (slot) begin
        m_force = m_force | tr;
        m_left--;
        if (m_left == 0) m_act = 0;
      end
      for (int i = lead_q.size() - 1; i >= 0; i--) if (lead_q[i].t == T) lead_q.delete(i);
      for (int i = ret_q.size() - 1; i >= 0; i--)  if (ret_q[i].t == T)  ret_q.delete(i);
      T++;
    end
    if (sv && !busy) begin
      m_act = 1; m_wr = sw; m_left = 1 << sl; m_force = 0;
    end
    m_frz = !m_cke;
    m_cke = !sp;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, '0, 0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    scen = "R1 reset";
    chk("R1", int'(cke), 1, "cke");
    chk("R1", int'(dqm), 0, "dqm");
    chk("R1", int'(wr_oe), 0, "wr_oe");
    chk("R1", int'(rd_valid), 0, "rd_valid");
    chk("R1", int'(rd_be), 0, "rd_be");
    rst_n = 1'b1;
    idle(1);

    scen = "R6 write len4";
    step(1, 1, 2'd2, 2'b00, 0, 0);
    step(0, 0, 0, 2'b01, 0, 0);
    step(0, 0, 0, 2'b10, 0, 0);
    step(0, 0, 0, 2'b11, 0, 0);
    step(0, 0, 0, 2'b00, 0, 0);
    idle(2);

    scen = "R7 read len8";
    step(1, 0, 2'd3, 2'b00, 0, 0);
    for (int i = 0; i < 8; i++) step(0, 0, 0, NB'(i), 0, 0);
    idle(5);

    scen = "R10 read len2 with freeze";
    step(1, 0, 2'd1, 2'b00, 0, 0);
    step(0, 0, 0, 2'b01, 0, 1);
    step(0, 0, 0, 2'b10, 0, 1);
    step(0, 0, 0, 2'b00, 0, 0);
    step(0, 0, 0, 2'b00, 0, 1);
    idle(6);

    scen = "R9 write len8 trunc then freeze";
    step(1, 1, 2'd3, 2'b00, 0, 0);
    step(0, 0, 0, 2'b01, 0, 0);
    step(0, 0, 0, 2'b00, 1, 1);
    step(0, 0, 0, 2'b00, 0, 0);
    for (int i = 0; i < 8; i++) step(0, 0, 0, 2'b00, 0, 0);
    scen = "R9 next burst clean";
    step(1, 1, 2'd0, 2'b00, 0, 0);
    idle(3);

    scen = "R4 start while busy";
    step(1, 0, 2'd1, 2'b00, 0, 0);
    step(1, 1, 2'd3, 2'b00, 0, 0);
    step(1, 1, 2'd3, 2'b10, 0, 0);
    step(1, 1, 2'd3, 2'b00, 0, 0);
    step(1, 1, 2'd3, 2'b00, 0, 0);
    idle(10);

    scen = "R5 read len1 truncated";
    step(1, 0, 2'd0, 2'b00, 0, 0);
    step(0, 0, 0, 2'b00, 1, 0);
    idle(5);

    scen = "R10 mixed traffic";
    for (int i = 0; i < 600; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[3:0] == 4'd5, lfsr[4], lfsr[6:5], lfsr[8:7],
           lfsr[12:9] == 4'd9, lfsr[15:13] == 3'd2);
    end
    idle(20);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule